// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank

This block holds a bank of independent down-counting timers that software reaches over a simple register bus. Each channel owns a byte-wide control register and a full-width count register. Software loads a count, picks a behaviour (free-running, single expiry, or repeating) and sets the run bit. From then on the counter steps down by one on every clock. On expiry the channel pulses its own interrupt line, and the line's index matches the channel number.

The bus has a single-cycle write strobe and a combinational read path. `bus_rdata` always shows the register selected by `bus_addr`, so software can sample a running count at any time. Writing the count register loads the counter and also keeps the value as the reload value for repeating mode. Writing zero to the control register freezes the counter at its current value.

Top module: `tmr_bank`

## Requirements
- R1: Channel t (0 to 7) has its control register at byte address 8*t and its count register at byte address 8*t+4.
- R2: A control write takes only bits 7:0 of the write data: bit 0 is the run bit and bits 5:4 the mode (0 free-running, 1 single expiry, 2 repeating, 3 free-running). A control read returns the run bit at bit 0 and the mode at bits 5:4, with all other bits zero.
- R3: A count write loads the counter and the reload value with the full 32-bit data. A count read returns the live counter value.
- R4: While the run bit is set and the count is nonzero, the count drops by one per clock. In a cycle that writes either register of a channel, that channel does not step. With the run bit clear, the count holds.
- R5: In single-expiry mode, a running channel at zero expires: it raises its interrupt, clears its run bit, keeps its mode field, and stays at zero.
- R6: In repeating mode, a running channel at zero expires: it raises its interrupt and reloads the last written count, so interrupts recur every reload+1 cycles.
- R7: In free-running mode (mode 0 or 3), a running channel at zero wraps to 0xFFFFFFFF and raises no interrupt.
- R8: An interrupt is a one-cycle high pulse on `irq[t]`, asserted in the cycle after the clock edge at which channel t expired.
- R9: An address with bits 1:0 nonzero, or at 64 or above, reads as zero, and writes to it change no channel.
- R10: After synchronous reset every register reads zero and every interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 8 | Per-channel expiry pulse, bit t for channel t |

## Verification
The assertions assume that `bus_addr` and `bus_wdata` are stable around each rising edge and that a single strobe names a single register. Under that assumption at most one write enable fires per cycle, and a channel that is being written never steps. The stimulus changes inputs only on falling edges and holds the strobe for exactly one cycle per access. It keeps reset high for several cycles, so no check looks back into cycles before reset.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    localparam int TMR_NUM_CH  = 8;
    localparam int TMR_CNT_W   = 32;
    localparam int TMR_ADDR_W  = 8;
    localparam int TMR_SLOT_LG = 3;  // 8-byte slot per channel

    typedef enum logic [1:0] {
        MD_FREE     = 2'd0,
        MD_ONCE     = 2'd1,
        MD_CYCLIC   = 2'd2,
        MD_FREE_ALT = 2'd3
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e mode;
        logic      run;
    } tmr_ctrl_t;

    function automatic tmr_ctrl_t ctrl_from_bits(input logic [1:0] md, input logic rn);
        tmr_ctrl_t c;
        c.mode = tmr_mode_e'(md);
        c.run  = rn;
        return c;
    endfunction

    function automatic logic [7:0] ctrl_to_byte(input tmr_ctrl_t c);
        return {2'b00, c.mode, 3'b000, c.run};
    endfunction

    function automatic logic mode_expires(input tmr_mode_e m);
        return (m == MD_ONCE) || (m == MD_CYCLIC);
    endfunction

endpackage

// File: rtl/tmr_regmap.sv
`timescale 1ns/1ps
module tmr_regmap
    import tmr_pkg::*;
#(
    parameter int NUM_CH = TMR_NUM_CH,
    parameter int DATA_W = TMR_CNT_W,
    parameter int ADDR_W = TMR_ADDR_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            bus_wr,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [NUM_CH-1:0][7:0]          ctrl_rd,
    input  logic [NUM_CH-1:0][DATA_W-1:0]   cnt_rd,
    output logic [NUM_CH-1:0]               ctrl_we,
    output logic [NUM_CH-1:0]               cnt_we,
    output logic [DATA_W-1:0]               rdata
);

    localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int SPAN = NUM_CH << TMR_SLOT_LG;

    logic              hit;
    logic              sel_cnt;
    logic [CH_W-1:0]   ch;

    always_comb begin
        hit     = (bus_addr[1:0] == 2'b00) &&
                  ({{(32-ADDR_W){1'b0}}, bus_addr} < 32'(SPAN));
        sel_cnt = bus_addr[2];
        ch      = bus_addr[CH_W+2:3];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign ctrl_we[g] = bus_wr && hit && !sel_cnt && (ch == CH_W'(g));
        assign cnt_we[g]  = bus_wr && hit &&  sel_cnt && (ch == CH_W'(g));
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            if (sel_cnt) rdata = cnt_rd[ch];
            else         rdata = DATA_W'(ctrl_rd[ch]);
        end
    end

    // R1: one strobe lands on at most one register
    a_r1_single_target: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctrl_we, cnt_we}));

    // R9: a misaligned address reaches no register
    a_r9_misaligned_quiet: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> ((ctrl_we == '0) && (cnt_we == '0)));

endmodule

// File: rtl/tmr_chan.sv
`timescale 1ns/1ps
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W = TMR_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  tmr_ctrl_t         ctrl_new,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_new,
    output tmr_ctrl_t         ctrl_q,
    output logic [CNT_W-1:0]  count_q,
    output logic              irq_q
);

    logic [CNT_W-1:0] reload_q;
    tmr_ctrl_t        ctrl_d;
    logic [CNT_W-1:0] count_d;
    logic [CNT_W-1:0] reload_d;
    logic             expire;
    logic             at_zero;

    assign at_zero = (count_q == '0);

    always_comb begin
        ctrl_d   = ctrl_q;
        count_d  = count_q;
        reload_d = reload_q;
        expire   = 1'b0;
        if (ctrl_we) begin
            ctrl_d = ctrl_new;
        end else if (cnt_we) begin
            count_d  = cnt_new;
            reload_d = cnt_new;
        end else if (ctrl_q.run) begin
            if (!at_zero) begin
                count_d = count_q - 1'b1;
            end else begin
                expire = mode_expires(ctrl_q.mode);
                unique case (ctrl_q.mode)
                    MD_ONCE:   ctrl_d.run = 1'b0;
                    MD_CYCLIC: count_d = reload_q;
                    default:   count_d = '1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= ctrl_from_bits(2'b00, 1'b0);
            count_q  <= '0;
            reload_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_d;
            count_q  <= count_d;
            reload_q <= reload_d;
            irq_q    <= expire;
        end
    end

    // R3: a count write lands in the counter
    a_r3_load: assert property (@(posedge clk) disable iff (rst)
        cnt_we && !ctrl_we |=> count_q == $past(cnt_new));

    // R4: running and nonzero steps down by one
    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && !at_zero && !ctrl_we && !cnt_we) |=> count_q == $past(count_q) - 1'b1);

    // R4: stopped counter holds
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.run && !ctrl_we && !cnt_we) |=> $stable(count_q));

    // R5: single expiry stops the channel
    a_r5_once_stops: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && ctrl_q.mode == MD_ONCE && at_zero && !ctrl_we && !cnt_we)
        |=> (!ctrl_q.run && irq_q && count_q == '0));

    // R6: repeating mode reloads and pulses
    a_r6_reload: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && ctrl_q.mode == MD_CYCLIC && at_zero && !ctrl_we && !cnt_we)
        |=> (irq_q && count_q == $past(reload_q)));

    // R7: free-running never interrupts
    a_r7_free_silent: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && (ctrl_q.mode == MD_FREE || ctrl_q.mode == MD_FREE_ALT))
        |=> !irq_q);

    // R8: every pulse follows a running channel sitting at zero
    a_r8_pulse_source: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(ctrl_q.run && at_zero));

endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_CH = TMR_NUM_CH,
    parameter int CNT_W  = TMR_CNT_W,
    parameter int ADDR_W = TMR_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0]             ctrl_we;
    logic [NUM_CH-1:0]             cnt_we;
    logic [NUM_CH-1:0][7:0]        ctrl_rd;
    logic [NUM_CH-1:0][CNT_W-1:0]  cnt_rd;
    tmr_ctrl_t                     ctrl_wr_val;

    assign ctrl_wr_val = ctrl_from_bits(bus_wdata[5:4], bus_wdata[0]);

    tmr_regmap #(
        .NUM_CH (NUM_CH),
        .DATA_W (CNT_W),
        .ADDR_W (ADDR_W)
    ) u_map (
        .clk     (clk),
        .rst     (rst),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .ctrl_rd (ctrl_rd),
        .cnt_rd  (cnt_rd),
        .ctrl_we (ctrl_we),
        .cnt_we  (cnt_we),
        .rdata   (bus_rdata)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tmr_ctrl_t ctrl_q;

        tmr_chan #(
            .CNT_W(CNT_W)
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .ctrl_we (ctrl_we[g]),
            .ctrl_new(ctrl_wr_val),
            .cnt_we  (cnt_we[g]),
            .cnt_new (bus_wdata),
            .ctrl_q  (ctrl_q),
            .count_q (cnt_rd[g]),
            .irq_q   (irq[g])
        );

        assign ctrl_rd[g] = ctrl_to_byte(ctrl_q);
    end

    // R9: misaligned reads return zero
    a_r9_misaligned_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[1:0] != 2'b00) |-> (bus_rdata == '0));

    // R2: unused control bits read back as zero
    a_r2_ctrl_pad: assert property (@(posedge clk) disable iff (rst)
        (bus_addr[2:0] == 3'b000) |-> (bus_rdata[CNT_W-1:6] == '0 && bus_rdata[3:1] == 3'b000));

endmodule

// File: tb/test_tmr_bank.sv
`timescale 1ns/1ps
module test_tmr_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_bank i_tmr_bank (
        .clk      (clk),
        .rst      (rst),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq      (irq)
    );

    // behavioural reference
    int unsigned m_cnt [8];
    int unsigned m_rel [8];
    bit          m_run [8];
    bit [1:0]    m_mode[8];
    bit [7:0]    m_irq;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        int c;
        if (a[1:0] != 2'b00 || a >= 8'd64) return 32'h0;
        c = int'(a >> 3);
        if (a[2]) return m_cnt[c];
        return {26'h0, m_mode[c], 3'b000, m_run[c]};
    endfunction

    always @(posedge clk) begin
        bit wr_ok;
        int wc;
        wr_ok = bus_wr && bus_addr[1:0] == 2'b00 && bus_addr < 8'd64;
        wc    = int'(bus_addr >> 3);
        if (rst) begin
            for (int i = 0; i < 8; i++) begin
                m_cnt[i] = 0; m_rel[i] = 0; m_run[i] = 0; m_mode[i] = 0;
            end
            m_irq = '0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                m_irq[i] = 1'b0;
                if (wr_ok && wc == i && !bus_addr[2]) begin
                    m_run[i]  = bus_wdata[0];
                    m_mode[i] = bus_wdata[5:4];
                end else if (wr_ok && wc == i && bus_addr[2]) begin
                    m_cnt[i] = bus_wdata;
                    m_rel[i] = bus_wdata;
                end else if (m_run[i]) begin
                    if (m_cnt[i] != 0) m_cnt[i] = m_cnt[i] - 1;
                    else if (m_mode[i] == 2'd1) begin m_irq[i] = 1'b1; m_run[i] = 1'b0; end
                    else if (m_mode[i] == 2'd2) begin m_irq[i] = 1'b1; m_cnt[i] = m_rel[i]; end
                    else m_cnt[i] = 32'hFFFF_FFFF;
                end
            end
        end
        #2;
        if (!rst && !done) begin
            chk("R8 irq vs model", {24'h0, irq}, {24'h0, m_irq});
            chk("R3 rdata vs model", bus_rdata, model_read(bus_addr));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        int pulses;
        tick(4);
        rst = 1'b0;

        // R10 reset state
        rd(8'h00, 32'h0, "R10 ctrl0 after reset");
        rd(8'h3C, 32'h0, "R10 count7 after reset");
        chk("R10 irq after reset", {24'h0, irq}, 32'h0);

        // R3 load, R2 readback, R4 stepping, R5 single expiry on channel 2
        wr(8'h14, 32'd5);
        rd(8'h14, 32'd5, "R3 count load");
        wr(8'h10, 32'hFFFF_FF11);
        rd(8'h10, 32'h11, "R2 ctrl byte readback");
        rd(8'h14, 32'd5, "R4 no step in write cycle");
        tick(3);
        rd(8'h14, 32'd2, "R4 step down");
        tick(2);
        rd(8'h14, 32'd0, "R4 reach zero");
        tick(1);
        chk("R8 irq index 2", {24'h0, irq}, 32'h04);
        rd(8'h10, 32'h10, "R5 run bit cleared");
        tick(1);
        chk("R8 pulse one cycle", {24'h0, irq}, 32'h0);
        tick(5);
        rd(8'h14, 32'd0, "R5 stays at zero");

        // R6 repeating mode on channel 5
        wr(8'h2C, 32'd3);
        wr(8'h28, 32'h21);
        pulses = 0;
        for (int k = 0; k < 16; k++) begin
            tick(1);
            if (irq[5]) pulses++;
        end
        chk("R6 pulse count", 32'(pulses), 32'd4);
        rd(8'h2C, 32'd3, "R6 reload value");

        // R7 free-running wrap on channel 0
        wr(8'h04, 32'd1);
        wr(8'h00, 32'h01);
        tick(2);
        rd(8'h04, 32'hFFFF_FFFF, "R7 wrap");
        chk("R7 no irq", {31'h0, irq[0]}, 32'h0);

        // R4 hold when stopped
        wr(8'h00, 32'h0);
        tick(5);
        rd(8'h04, 32'hFFFF_FFFF, "R4 hold while stopped");

        // R9 unmapped accesses
        wr(8'h06, 32'h1234_5678);
        wr(8'h40, 32'h0000_0001);
        rd(8'h04, 32'hFFFF_FFFF, "R9 misaligned write ignored");
        rd(8'h06, 32'h0, "R9 misaligned read");
        rd(8'h40, 32'h0, "R9 out of range read");
        rd(8'h00, 32'h0, "R9 ctrl0 untouched");

        // R2 and R7 mode 3 on channel 6
        wr(8'h34, 32'h0);
        wr(8'h30, 32'hFFFF_FFFF);
        rd(8'h30, 32'h31, "R2 mode 3 readback");
        tick(1);
        rd(8'h34, 32'hFFFF_FFFF, "R7 mode 3 wrap");
        chk("R7 mode 3 no irq", {31'h0, irq[6]}, 32'h0);

        // R1 last slot
        wr(8'h3C, 32'hA5A5_0000);
        rd(8'h3C, 32'hA5A5_0000, "R1 channel 7 count slot");
        rd(8'h38, 32'h0, "R1 channel 7 ctrl slot");

        tick(20);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule